// File: doc/BRIEF.md
# BCD Time-of-Day Calendar Counter

This block keeps wall-clock time and calendar date in eight byte-wide registers, each holding binary coded decimal digits: hundredths of a second, seconds, minutes, hours, weekday, day of month, month and two-digit year. It advances one hundredth of a second for every qualified pulse of a 100 Hz tick enable. It rolls every field over into the next, and it gives each month its true length, with February leap-year correction that is valid up to the end of 2099.

The hour byte carries its own mode flag. In 12-hour mode a further bit of that byte marks the afternoon. In 24-hour mode the same bit is the upper tens digit. The weekday byte also carries two control bits. One of them stops the clock. The other is a reset-pin enable that the block stores for the surrounding serial access logic. That access logic writes a complete new time through a parallel load port and reads the registers through a parallel read port.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the read port shows, byte 0 to byte 7: 0x00, 0x00, 0x00, 0x00 (24-hour midnight), 0x31 (clock stopped, reset-pin enable set, weekday 1), 0x01, 0x01 and 0x00.
- R2: With the clock running, each tick increments byte 0 (hundredths) through 00-99. Byte 0 carries into byte 1 (seconds, 00-59), and byte 1 carries into byte 2 (minutes, 00-59). The result is visible on the read port in the cycle after the tick.
- R3: Byte 3 bit 7 set selects 12-hour mode, with hours 01-12 held in bit 4 (tens) and bits 3:0, and bit 5 meaning PM. Hour 11 advances to 12 and inverts bit 5. Hour 12 advances to 01 with bit 5 unchanged. The step from 11 PM to 12 AM also advances the date.
- R4: With byte 3 bit 7 clear, hours run 00-23 with bits 5:4 as the tens digit. Hour 23 advances to 00 and advances the date.
- R5: Byte 5 (date) wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. Each wrap increments byte 6 (month).
- R6: In February the date wraps after 29 when the BCD year is divisible by four, 00 included, and after 28 in other years.
- R7: The following bits always read 0, whatever is loaded: byte 1 bit 7, byte 2 bit 7, byte 3 bit 6, byte 4 bits 7, 6 and 3, byte 5 bits 7:6, and byte 6 bits 7:5.
- R8: A load pulse writes all eight bytes at once (byte i from load bits 8i+7:8i). The written value appears in the next cycle, takes precedence over a tick in the same cycle, and clears the tick prescaler.
- R9: While byte 4 bit 5 is 1 the tick input has no effect on any register.
- R10: Byte 4 bit 4 (reset-pin enable) is stored and read back unchanged while the clock runs.
- R11: Each date advance also steps the weekday (byte 4 bits 2:0) from 7 back to 1, with bits 5:4 kept. Month 12 wraps to 01 and increments byte 7 (year), which wraps from 99 to 00.
- R12: With neither tick nor load asserted the registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | 100 Hz advance enable, one cycle per pulse |
| load_en | input | 1 | Writes all eight bytes from load_data |
| load_data | input | 64 | New register contents, byte i in bits 8i+7:8i |
| time_q | output | 64 | Current register contents, same layout |

## Verification
The assertions assume that every loaded byte holds legal BCD within its field's range, that a loaded date exists in the loaded month, and that tick_en is a single-cycle pulse. The bench therefore loads only valid calendar values, including the edge values 23:59:59.99, 11 PM in 12-hour mode, month ends and the end of year 99. It relies on the masking rule of R7 only through bits that R7 names, and it never loads an out-of-range digit.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

    localparam int NUM_REGS  = 8;
    localparam int REG_W     = 8;
    localparam int WORD_W    = NUM_REGS * REG_W;

    // register indices
    localparam int IDX_HUND  = 0;
    localparam int IDX_SEC   = 1;
    localparam int IDX_MIN   = 2;
    localparam int IDX_HOUR  = 3;
    localparam int IDX_WDAY  = 4;
    localparam int IDX_DATE  = 5;
    localparam int IDX_MONTH = 6;
    localparam int IDX_YEAR  = 7;

    // bit positions inside the hour and weekday bytes
    localparam int HR_MODE12 = 7;
    localparam int HR_PM     = 5;
    localparam int WD_HALT   = 5;
    localparam int WD_RSTEN  = 4;

    // bits forced to zero, byte 7 .. byte 0
    localparam logic [WORD_W-1:0] ZERO_MASK = 64'h00E0_C0C8_4080_8000;

    // reset image, byte 7 .. byte 0
    localparam logic [WORD_W-1:0] RESET_IMAGE = 64'h0001_0131_0000_0000;

    typedef logic [NUM_REGS-1:0][REG_W-1:0] regfile_t;

    typedef struct packed {
        regfile_t regs;
    } cal_state_t;

    // increment a two-digit BCD byte
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] == 4'd9) begin
            r = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

    // step a byte, wrapping from last to first; MSB of result is the carry
    function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] last,
                                            input logic [7:0] first);
        logic [8:0] r;
        if (v == last) begin
            r = {1'b1, first};
        end else begin
            r = {1'b0, bcd_inc(v)};
        end
        return r;
    endfunction

endpackage

// File: rtl/bcd_cal_prescale.sv
module bcd_cal_prescale #(
    parameter int TICK_DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic clear,
    output logic advance
);

    generate
        if (TICK_DIV <= 1) begin : g_direct
            assign advance = tick_en;
        end else begin : g_divided
            localparam int CNT_W = $clog2(TICK_DIV);
            localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

            logic [CNT_W-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (clear) begin
                    cnt_d = '0;
                end else if (tick_en) begin
                    cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + CNT_W'(1);
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign advance = tick_en && !clear && (cnt_q == CNT_LAST);

            a_r8_prescale_cleared: assert property (@(posedge clk) disable iff (!rst_n)
                clear |=> (cnt_q == '0))
                else $error("prescaler not cleared by load");
        end
    endgenerate

endmodule

// File: rtl/bcd_cal_month_len.sv
module bcd_cal_month_len (
    input  logic [7:0] month_bcd,
    input  logic [7:0] year_bcd,
    output logic [7:0] last_date_bcd
);

    logic [4:0] year_mod_sel;
    logic       leap;

    // 10*t mod 4 equals 2*t mod 4, so the year is a multiple of four
    // exactly when 2*tens + units is
    always_comb begin
        year_mod_sel  = {year_bcd[7:4], 1'b0} + {1'b0, year_bcd[3:0]};
        leap          = (year_mod_sel[1:0] == 2'b00);
        unique case (month_bcd)
            8'h02:                      last_date_bcd = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date_bcd = 8'h30;
            default:                    last_date_bcd = 8'h31;
        endcase
    end

endmodule

// File: rtl/bcd_cal_hour_step.sv
module bcd_cal_hour_step (
    input  logic [7:0] hour_in,
    output logic [7:0] hour_out,
    output logic       day_carry
);

    import bcd_cal_pkg::*;

    logic       mode12;
    logic       pm;
    logic [7:0] v12;
    logic [7:0] v24;
    logic [8:0] s24;

    always_comb begin
        mode12    = hour_in[HR_MODE12];
        pm        = hour_in[HR_PM];
        v12       = {3'b000, hour_in[4:0]};
        v24       = {2'b00, hour_in[5:0]};
        s24       = bcd_step(v24, 8'h23, 8'h00);
        hour_out  = hour_in;
        day_carry = 1'b0;
        if (mode12) begin
            if (v12 == 8'h11) begin
                hour_out  = {1'b1, 1'b0, ~pm, 5'h12};
                day_carry = pm;
            end else if (v12 == 8'h12) begin
                hour_out  = {1'b1, 1'b0, pm, 5'h01};
            end else begin
                v12       = bcd_inc(v12);
                hour_out  = {1'b1, 1'b0, pm, v12[4:0]};
            end
        end else begin
            hour_out  = {2'b00, s24[5:0]};
            day_carry = s24[8];
        end
    end

endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core #(
    parameter int TICK_DIV = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        load_en,
    input  logic [63:0] load_data,
    output logic [63:0] time_q
);

    import bcd_cal_pkg::*;

    cal_state_t st_d, st_q;

    logic       advance;
    logic       halted;
    logic [7:0] hour_next;
    logic       hour_carry;
    logic [7:0] last_date;

    bcd_cal_prescale #(.TICK_DIV(TICK_DIV)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .clear   (load_en),
        .advance (advance)
    );

    bcd_cal_hour_step u_hour (
        .hour_in   (st_q.regs[IDX_HOUR]),
        .hour_out  (hour_next),
        .day_carry (hour_carry)
    );

    bcd_cal_month_len u_mlen (
        .month_bcd     (st_q.regs[IDX_MONTH]),
        .year_bcd      (st_q.regs[IDX_YEAR]),
        .last_date_bcd (last_date)
    );

    assign halted = st_q.regs[IDX_WDAY][WD_HALT];

    always_comb begin
        logic [8:0] s_hund, s_sec, s_min, s_date, s_mon, s_year;
        logic [2:0] wd;
        st_d   = st_q;
        s_hund = bcd_step(st_q.regs[IDX_HUND],  8'h99, 8'h00);
        s_sec  = bcd_step(st_q.regs[IDX_SEC],   8'h59, 8'h00);
        s_min  = bcd_step(st_q.regs[IDX_MIN],   8'h59, 8'h00);
        s_date = bcd_step(st_q.regs[IDX_DATE],  last_date, 8'h01);
        s_mon  = bcd_step(st_q.regs[IDX_MONTH], 8'h12, 8'h01);
        s_year = bcd_step(st_q.regs[IDX_YEAR],  8'h99, 8'h00);
        wd     = st_q.regs[IDX_WDAY][2:0];
        if (load_en) begin
            st_d.regs = regfile_t'(load_data & ~ZERO_MASK);
        end else if (advance && !halted) begin
            st_d.regs[IDX_HUND] = s_hund[7:0];
            if (s_hund[8]) begin
                st_d.regs[IDX_SEC] = s_sec[7:0];
                if (s_sec[8]) begin
                    st_d.regs[IDX_MIN] = s_min[7:0];
                    if (s_min[8]) begin
                        st_d.regs[IDX_HOUR] = hour_next;
                        if (hour_carry) begin
                            st_d.regs[IDX_WDAY][2:0] = (wd == 3'd7) ? 3'd1 : wd + 3'd1;
                            st_d.regs[IDX_DATE]      = s_date[7:0];
                            if (s_date[8]) begin
                                st_d.regs[IDX_MONTH] = s_mon[7:0];
                                if (s_mon[8]) begin
                                    st_d.regs[IDX_YEAR] = s_year[7:0];
                                end
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.regs <= regfile_t'(RESET_IMAGE);
        end else begin
            st_q <= st_d;
        end
    end

    assign time_q = WORD_W'(st_q.regs);

    // assertions

    a_r8_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (time_q == $past(load_data & ~ZERO_MASK)))
        else $error("load did not land intact");

    a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !load_en) |=> $stable(time_q))
        else $error("registers moved while halted");

    a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load_en) |=> $stable(time_q))
        else $error("registers moved without tick or load");

    a_r7_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        ((time_q & ZERO_MASK) == '0))
        else $error("reserved bit reads one");

    a_r2_hund_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !halted && !load_en) |=> (time_q[7:0] != $past(time_q[7:0])))
        else $error("hundredths did not advance");

    a_r10_rsten_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> (time_q[8*IDX_WDAY+WD_RSTEN] == $past(time_q[8*IDX_WDAY+WD_RSTEN])))
        else $error("reset-pin enable changed without load");

    a_r3_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> (time_q[8*IDX_HOUR+HR_MODE12] == $past(time_q[8*IDX_HOUR+HR_MODE12])))
        else $error("hour mode changed without load");

endmodule

// File: tb/bcd_calendar_core_bench.sv
module bcd_calendar_core_bench;

    logic        clk;
    logic        rst_n;
    logic        tick_en;
    logic        load_en;
    logic [63:0] load_data;
    logic [63:0] time_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    bcd_calendar_core u_bcd_calendar_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .load_en   (load_en),
        .load_data (load_data),
        .time_q    (time_q)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic logic [63:0] pk(input logic [7:0] hu, se, mi, ho, wd, dt, mo, yr);
        return {yr, mo, dt, wd, ho, mi, se, hu};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic do_load(input logic [63:0] v);
        load_en   = 1'b1;
        load_data = v;
        @(negedge clk);
        load_en   = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R1 reset image", time_q, pk(8'h00,8'h00,8'h00,8'h00,8'h31,8'h01,8'h01,8'h00));
        do_ticks(3);
        chk("R9 halted from reset", time_q, pk(8'h00,8'h00,8'h00,8'h00,8'h31,8'h01,8'h01,8'h00));
    endtask

    task automatic t_count;
        do_load(pk(8'h78,8'h56,8'h34,8'h12,8'h03,8'h15,8'h06,8'h24));
        chk("R8 load visible", time_q, pk(8'h78,8'h56,8'h34,8'h12,8'h03,8'h15,8'h06,8'h24));
        do_ticks(1);
        chk("R2 single tick", time_q, pk(8'h79,8'h56,8'h34,8'h12,8'h03,8'h15,8'h06,8'h24));
        do_ticks(21);
        chk("R2 hundredths carry", time_q, pk(8'h00,8'h57,8'h34,8'h12,8'h03,8'h15,8'h06,8'h24));
    endtask

    task automatic t_idle;
        repeat (4) @(negedge clk);
        chk("R12 idle hold", time_q, pk(8'h00,8'h57,8'h34,8'h12,8'h03,8'h15,8'h06,8'h24));
    endtask

    task automatic t_24h;
        do_load(pk(8'h99,8'h59,8'h59,8'h23,8'h03,8'h15,8'h06,8'h24));
        do_ticks(1);
        chk("R4 midnight wrap", time_q, pk(8'h00,8'h00,8'h00,8'h00,8'h04,8'h16,8'h06,8'h24));
        do_load(pk(8'h99,8'h59,8'h59,8'h19,8'h03,8'h15,8'h06,8'h24));
        do_ticks(1);
        chk("R4 19 to 20", time_q, pk(8'h00,8'h00,8'h00,8'h20,8'h03,8'h15,8'h06,8'h24));
    endtask

    task automatic t_12h;
        do_load(pk(8'h99,8'h59,8'h59,8'h91,8'h03,8'h15,8'h06,8'h24));
        do_ticks(1);
        chk("R3 11AM to 12PM", time_q, pk(8'h00,8'h00,8'h00,8'hB2,8'h03,8'h15,8'h06,8'h24));
        do_load(pk(8'h99,8'h59,8'h59,8'hB2,8'h03,8'h15,8'h06,8'h24));
        do_ticks(1);
        chk("R3 12PM to 1PM", time_q, pk(8'h00,8'h00,8'h00,8'hA1,8'h03,8'h15,8'h06,8'h24));
        do_load(pk(8'h99,8'h59,8'h59,8'hB1,8'h03,8'h15,8'h06,8'h24));
        do_ticks(1);
        chk("R3 11PM to 12AM next day", time_q, pk(8'h00,8'h00,8'h00,8'h92,8'h04,8'h16,8'h06,8'h24));
    endtask

    task automatic t_month;
        do_load(pk(8'h99,8'h59,8'h59,8'h23,8'h03,8'h30,8'h04,8'h24));
        do_ticks(1);
        chk("R5 april end", time_q, pk(8'h00,8'h00,8'h00,8'h00,8'h04,8'h01,8'h05,8'h24));
        do_load(pk(8'h99,8'h59,8'h59,8'h23,8'h03,8'h30,8'h01,8'h24));
        do_ticks(1);
        chk("R5 january 30 to 31", time_q, pk(8'h00,8'h00,8'h00,8'h00,8'h04,8'h31,8'h01,8'h24));
        do_ticks(8640000 / 8640000); // placeholder-free: one more tick only moves hundredths
        chk("R5 mid-day tick", time_q, pk(8'h01,8'h00,8'h00,8'h00,8'h04,8'h31,8'h01,8'h24));
        do_load(pk(8'h99,8'h59,8'h59,8'h23,8'h03,8'h31,8'h01,8'h24));
        do_ticks(1);
        chk("R5 january end", time_q, pk(8'h00,8'h00,8'h00,8'h00,8'h04,8'h01,8'h02,8'h24));
        do_load(pk(8'h99,8'h59,8'h59,8'h23,8'h03,8'h30,8'h11,8'h24));
        do_ticks(1);
        chk("R5 november end", time_q, pk(8'h00,8'h00,8'h00,8'h00,8'h04,8'h01,8'h12,8'h24));
    endtask

    task automatic t_feb;
        do_load(pk(8'h99,8'h59,8'h59,8'h23,8'h03,8'h28,8'h02,8'h24));
        do_ticks(1);
        chk("R6 leap 28 to 29", time_q, pk(8'h00,8'h00,8'h00,8'h00,8'h04,8'h29,8'h02,8'h24));
        do_load(pk(8'h99,8'h59,8'h59,8'h23,8'h03,8'h29,8'h02,8'h24));
        do_ticks(1);
        chk("R6 leap 29 wraps", time_q, pk(8'h00,8'h00,8'h00,8'h00,8'h04,8'h01,8'h03,8'h24));
        do_load(pk(8'h99,8'h59,8'h59,8'h23,8'h03,8'h28,8'h02,8'h23));
        do_ticks(1);
        chk("R6 common 28 wraps", time_q, pk(8'h00,8'h00,8'h00,8'h00,8'h04,8'h01,8'h03,8'h23));
        do_load(pk(8'h99,8'h59,8'h59,8'h23,8'h03,8'h28,8'h02,8'h00));
        do_ticks(1);
        chk("R6 year 00 leap", time_q, pk(8'h00,8'h00,8'h00,8'h00,8'h04,8'h29,8'h02,8'h00));
        do_load(pk(8'h99,8'h59,8'h59,8'h23,8'h03,8'h28,8'h02,8'h18));
        do_ticks(1);
        chk("R6 year 18 common", time_q, pk(8'h00,8'h00,8'h00,8'h00,8'h04,8'h01,8'h03,8'h18));
    endtask

    task automatic t_year;
        do_load(pk(8'h99,8'h59,8'h59,8'h23,8'h07,8'h31,8'h12,8'h99));
        do_ticks(1);
        chk("R11 century wrap", time_q, pk(8'h00,8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00));
        do_load(pk(8'h99,8'h59,8'h59,8'h23,8'h05,8'h31,8'h12,8'h19));
        do_ticks(1);
        chk("R11 year 19 to 20", time_q, pk(8'h00,8'h00,8'h00,8'h00,8'h06,8'h01,8'h01,8'h20));
    endtask

    task automatic t_zero_and_halt;
        do_load(pk(8'h42,8'hC5,8'hB3,8'h55,8'hFB,8'hD7,8'hE9,8'h88));
        chk("R7 reserved bits masked", time_q, pk(8'h42,8'h45,8'h33,8'h15,8'h33,8'h17,8'h09,8'h88));
        do_ticks(5);
        chk("R9 ticks ignored when halted", time_q, pk(8'h42,8'h45,8'h33,8'h15,8'h33,8'h17,8'h09,8'h88));
    endtask

    task automatic t_rsten;
        do_load(pk(8'h10,8'h00,8'h00,8'h08,8'h12,8'h01,8'h01,8'h30));
        do_ticks(2);
        chk("R10 reset-pin enable kept", time_q, pk(8'h12,8'h00,8'h00,8'h08,8'h12,8'h01,8'h01,8'h30));
    endtask

    task automatic t_priority;
        tick_en   = 1'b1;
        load_en   = 1'b1;
        load_data = pk(8'h50,8'h00,8'h00,8'h08,8'h02,8'h01,8'h01,8'h30);
        @(negedge clk);
        tick_en   = 1'b0;
        load_en   = 1'b0;
        chk("R8 load beats tick", time_q, pk(8'h50,8'h00,8'h00,8'h08,8'h02,8'h01,8'h01,8'h30));
    endtask

    initial begin
        #100us;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        tick_en   = 1'b0;
        load_en   = 1'b0;
        load_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_idle();
        t_24h();
        t_12h();
        t_month();
        t_feb();
        t_year();
        t_zero_and_halt();
        t_rsten();
        t_priority();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule